// File: doc/BRIEF.md
# Video Line Timing Generator

This block sets the horizontal rhythm of a character-based video raster. It runs on the CPU clock, nominally 3.25 MHz. A free-running 8-bit counter divides that clock into lines of 208 cycles, which gives 64 µs per line and a 15.625 kHz line rate. The counter wraps by itself at the end of each line. It also restarts at once when the processor acknowledges its end-of-row interrupt, so on text lines the line boundary follows that handshake.

Every line begins with three back-to-back 16-cycle windows: a front porch, an active-low horizontal sync and a back porch. The windows advance on the falling edge of counter bit 3, which ticks once every 16 cycles. A second, shorter front-porch output covers only the final 4, 5 or 6 cycles of the first window, or the whole window, as chosen by a 2-bit select. A one-cycle strobe marks the first cycle of every line. Mixing these signals into composite video is left to logic outside this block.

Top module: `line_timer`

## Requirements
- R1: With `iack_i` held low, `line_start_o` pulses exactly once every 208 clock cycles. The line count runs 0 to 207.
- R2: The wrap point is found by decoding counter bits 0–3, 6 and 7 all set, with bits 4 and 5 ignored. The first match is 207 (0xCF), and after it the count returns to 0.
- R3: `line_start_o` is high exactly in the cycles where the line count is 0. Only an acknowledge in such a cycle can keep it high for two cycles in a row.
- R4: `front_porch_o` is high exactly while the line count is 0 to 15.
- R5: `hsync_n_o` is low exactly while the line count is 16 to 31, and high otherwise.
- R6: `back_porch_o` is high exactly while the line count is 32 to 47.
- R7: `fp_trim_o` is high while the line count is 0–15 and the low four count bits are at least 16−N. N depends on `trim_sel_i` as sampled one cycle earlier: 0 selects the full window (N=16), 1 selects N=4, 2 selects N=5 and 3 selects N=6.
- R8: Reset is synchronous and active high. While `rst_i` is high, and in the first cycle after it falls, the count is 0: `line_start_o`=1, `front_porch_o`=1, `hsync_n_o`=1 and `back_porch_o`=0.
- R9: When `iack_i` is high at a clock edge, the count after that edge is 0, whatever its value was. Any sync or porch window that is running is cut short, and the sequence starts again from the front porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock (3.25 MHz nominal) |
| rst_i | input | 1 | Synchronous reset, active high |
| iack_i | input | 1 | Interrupt-acknowledge strobe; restarts the line |
| trim_sel_i | input | 2 | Trimmed front-porch length select |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| front_porch_o | output | 1 | Full 16-cycle front-porch window |
| back_porch_o | output | 1 | 16-cycle back-porch window |
| fp_trim_o | output | 1 | Trimmed front-porch window |
| line_start_o | output | 1 | One-cycle strobe at count 0 |

## Verification
Some properties are checked on every cycle: the three windows never overlap, sync always follows a porch and is followed by one, the count never passes the wrap value, an acknowledge always leads to a line start, and the trimmed porch lies inside the full one. The exact cycle positions of each window, the 208-cycle period and the cycle counts of each trim setting are only visible through the bench's scenarios. The same holds for windows cut short by an acknowledge that arrives in different slots. The bench compares all of these against a behavioural count model.

// File: rtl/line_timer_pkg.sv
package line_timer_pkg;

    // Counter geometry
    localparam int CNT_W      = 8;
    localparam int SLOT_LOG2  = 4;
    localparam int SLOT_LEN   = 1 << SLOT_LOG2;
    localparam int NUM_SLOTS  = 3;
    localparam logic [CNT_W-1:0] TERM_MASK = 8'hCF;

    // Slot order inside the pulse chain: bit position = slot index
    typedef enum int unsigned {
        SLOT_FRONT = 0,
        SLOT_SYNC  = 1,
        SLOT_BACK  = 2
    } slot_idx_e;

    typedef enum logic [1:0] {
        TRIM_FULL = 2'd0,
        TRIM_4    = 2'd1,
        TRIM_5    = 2'd2,
        TRIM_6    = 2'd3
    } trim_sel_e;

    typedef struct packed {
        logic back;
        logic sync;
        logic front;
    } pulse_t;

    // Number of active cycles at the tail of the first slot
    function automatic logic [SLOT_LOG2:0] trim_len(input trim_sel_e sel);
        case (sel)
            TRIM_4:  trim_len = (SLOT_LOG2+1)'(4);
            TRIM_5:  trim_len = (SLOT_LOG2+1)'(5);
            TRIM_6:  trim_len = (SLOT_LOG2+1)'(6);
            default: trim_len = (SLOT_LOG2+1)'(SLOT_LEN);
        endcase
    endfunction

    // True when a phase within the slot lies in the trimmed tail
    function automatic logic trim_hit(input logic [SLOT_LOG2-1:0] phase,
                                      input trim_sel_e sel);
        logic [SLOT_LOG2:0] first;
        first    = (SLOT_LOG2+1)'(SLOT_LEN) - trim_len(sel);
        trim_hit = ({1'b0, phase} >= first);
    endfunction

endpackage

// File: rtl/line_timer_counter.sv
module line_timer_counter
    import line_timer_pkg::*;
#(
    parameter int               W    = CNT_W,
    parameter logic [W-1:0]     MASK = TERM_MASK
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         iack_i,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         term_o
);

    // Partial decode: only bits set in MASK are examined
    assign term_o = ((cnt_q & MASK) == MASK);

    always_comb begin
        if (rst_i || term_o || iack_i) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/line_timer_chain.sv
module line_timer_chain
    import line_timer_pkg::*;
#(
    parameter int N = NUM_SLOTS
) (
    input  logic         clk_i,
    input  logic         restart_i,   // next count is zero
    input  logic         tap_now_i,   // slot-clock bit, current count
    input  logic         tap_nxt_i,   // slot-clock bit, next count
    output logic [N-1:0] slots_q
);

    logic         tick;
    logic [N-1:0] slots_d;

    // Falling edge of the slot-clock tap advances the chain
    assign tick = tap_now_i & ~tap_nxt_i;

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_comb begin
                    if (restart_i)   slots_d[i] = 1'b1;
                    else if (tick)   slots_d[i] = 1'b0;
                    else             slots_d[i] = slots_q[i];
                end
            end else begin : g_tail
                always_comb begin
                    if (restart_i)   slots_d[i] = 1'b0;
                    else if (tick)   slots_d[i] = slots_q[i-1];
                    else             slots_d[i] = slots_q[i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        slots_q <= slots_d;
    end

endmodule

// File: rtl/line_timer_trim.sv
module line_timer_trim
    import line_timer_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 first_slot_i,
    input  logic [SLOT_LOG2-1:0] phase_i,
    input  logic [1:0]           sel_i,
    output logic                 trim_q
);

    trim_sel_e sel_e;
    assign sel_e = trim_sel_e'(sel_i);

    always_ff @(posedge clk_i) begin
        trim_q <= first_slot_i & trim_hit(phase_i, sel_e);
    end

endmodule

// File: rtl/line_timer.sv
module line_timer
    import line_timer_pkg::*;
#(
    parameter int                W    = CNT_W,
    parameter logic [W-1:0]      MASK = TERM_MASK
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       iack_i,
    input  logic [1:0] trim_sel_i,
    output logic       hsync_n_o,
    output logic       front_porch_o,
    output logic       back_porch_o,
    output logic       fp_trim_o,
    output logic       line_start_o
);

    localparam logic [W-1:0] FIRST_END = W'(SLOT_LEN);
    localparam int           TAP       = SLOT_LOG2 - 1;

    logic [W-1:0]         cnt_q;
    logic [W-1:0]         cnt_nxt;
    logic                 term;
    logic                 restart;
    logic                 first_slot;
    logic [NUM_SLOTS-1:0] slots_q;
    pulse_t               pulses;
    logic                 ls_q;

    line_timer_counter #(.W(W), .MASK(MASK)) u_counter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .iack_i  (iack_i),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .term_o  (term)
    );

    assign restart    = (cnt_nxt == '0);
    assign first_slot = (cnt_nxt < FIRST_END);

    line_timer_chain #(.N(NUM_SLOTS)) u_chain (
        .clk_i     (clk_i),
        .restart_i (restart),
        .tap_now_i (cnt_q[TAP]),
        .tap_nxt_i (cnt_nxt[TAP]),
        .slots_q   (slots_q)
    );

    line_timer_trim u_trim (
        .clk_i        (clk_i),
        .first_slot_i (first_slot),
        .phase_i      (cnt_nxt[SLOT_LOG2-1:0]),
        .sel_i        (trim_sel_i),
        .trim_q       (fp_trim_o)
    );

    always_ff @(posedge clk_i) begin
        ls_q <= restart;
    end

    assign pulses.front = slots_q[SLOT_FRONT];
    assign pulses.sync  = slots_q[SLOT_SYNC];
    assign pulses.back  = slots_q[SLOT_BACK];

    assign front_porch_o = pulses.front;
    assign hsync_n_o     = ~pulses.sync;
    assign back_porch_o  = pulses.back;
    assign line_start_o  = ls_q;

endmodule

// File: rtl/line_timer_chk.sv
module line_timer_chk #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = 8'hCF
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         iack_i,
    input logic         hsync_n_o,
    input logic         front_porch_o,
    input logic         back_porch_o,
    input logic         fp_trim_o,
    input logic         line_start_o,
    input logic [W-1:0] cnt_q,
    input logic         term
);

    p_windows_disjoint_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({front_porch_o, ~hsync_n_o, back_porch_o}));

    p_sync_after_front_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hsync_n_o) |-> $past(front_porch_o));

    p_back_or_restart_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hsync_n_o) |-> (back_porch_o || front_porch_o));

    p_count_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= MASK);

    p_wrap_to_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        term |=> line_start_o);

    p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (line_start_o && !iack_i) |=> !line_start_o);

    p_iack_restart_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        iack_i |=> (line_start_o && front_porch_o));

    p_trim_inside_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        fp_trim_o |-> front_porch_o);

endmodule

bind line_timer line_timer_chk #(.W(W), .MASK(MASK)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .iack_i        (iack_i),
    .hsync_n_o     (hsync_n_o),
    .front_porch_o (front_porch_o),
    .back_porch_o  (back_porch_o),
    .fp_trim_o     (fp_trim_o),
    .line_start_o  (line_start_o),
    .cnt_q         (cnt_q),
    .term          (term)
);

// File: tb/line_timer_bench.sv
module line_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iack = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       hsync_n, fp, bp, fpt, ls;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ref_cnt = 0;
    int ref_sel = 0;
    bit model_ok = 1'b0;
    bit done = 1'b0;
    string phase_tag = "R8";

    always #5 clk = ~clk;

    line_timer u_line_timer (
        .clk_i         (clk),
        .rst_i         (rst),
        .iack_i        (iack),
        .trim_sel_i    (sel),
        .hsync_n_o     (hsync_n),
        .front_porch_o (fp),
        .back_porch_o  (bp),
        .fp_trim_o     (fpt),
        .line_start_o  (ls)
    );

    // Behavioural count model: line of 208 counts, reset/acknowledge to 0
    always @(posedge clk) begin
        cyc++;
        if (rst || iack || ref_cnt == 207) ref_cnt = 0;
        else ref_cnt = ref_cnt + 1;
        ref_sel = int'(sel);
        model_ok = 1'b1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] cyc=%0d cnt=%0d actual=%b expected=%b",
                     req, phase_tag, cyc, ref_cnt, act, exp);
        end
    endtask

    function automatic logic exp_trim(input int c, input int s);
        int n;
        n = (s == 1) ? 4 : (s == 2) ? 5 : (s == 3) ? 6 : 16;
        return (c < 16) && ((c % 16) >= 16 - n);
    endfunction

    // Compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (model_ok && !done) begin
            chk("R3 line_start", ls, ref_cnt == 0);
            chk("R4 front_porch", fp, ref_cnt < 16);
            chk("R5 hsync_n", hsync_n, !(ref_cnt >= 16 && ref_cnt < 32));
            chk("R6 back_porch", bp, ref_cnt >= 32 && ref_cnt < 48);
            chk("R7 fp_trim", fpt, exp_trim(ref_cnt, ref_sel));
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic iack_at(input int c);
        while (ref_cnt != c) @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        run(60);
    endtask

    // R1: period between strobes with no acknowledge
    task automatic measure_period;
        int gap;
        while (ls !== 1'b1) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (ls !== 1'b1 && gap < 400);
        n_cmp++;
        if (gap != 208) begin
            n_bad++;
            $display("FAIL R1 line period actual=%0d expected=208", gap);
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        run(3);                         // R8: reset held
        rst = 1'b0;
        phase_tag = "R1 R2 free run";
        measure_period();
        measure_period();
        run(300);
        phase_tag = "R7 trim";
        for (int s = 1; s < 4; s++) begin
            sel = 2'(s);
            run(250);
        end
        sel = 2'd0;
        run(20);
        phase_tag = "R9 R2 acknowledge";
        iack_at(5);                     // inside front porch
        iack_at(20);                    // inside sync
        iack_at(40);                    // inside back porch
        iack_at(100);
        iack_at(0);                     // back-to-back strobe
        iack_at(207);                   // coincides with wrap
        phase_tag = "R9 random";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            iack = ($urandom_range(0, 99) < 2);
            sel = 2'($urandom_range(0, 3));
        end
        iack = 1'b0;
        run(50);
        phase_tag = "R8 mid reset";
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(300);
        finish_run();
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            finish_run();
        end
    end

endmodule